// File: doc/BRIEF.md
# Processor Debug-Mode Entry Controller

This block decides when a small processor core stops and enters debug mode. A request comes from one of two places: a strobe from the decode of a JTAG debug instruction, or an external host pulling the shared debug-event line low. The line is active low and open-drain. The controller lets the current instruction retire and then waits for the next fetched instruction to reach the instruction latch before it halts the core. If the core is in its stop or wait low-power state when the request arrives, the controller raises a wake request and waits only for the next latch.

Once the core halts, the controller reports the halt on a two-bit operating-status field. It also pulls the same debug-event line low for a fixed number of cycles, which tells the host the halt has happened. The host must let the line go high again before its first command is taken. Any command offered before then is dropped. An accepted command with the go flag set leaves debug mode and lets the core run again.

The line is shown as a split pad: `evt_line_i` is the level read at the pin, and `evt_drive_o` enables the pull-down. The acknowledge length `ACK_CYCLES` must be at least 3. The synchronizer depth `SYNC_STAGES` must be at least 2.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the block in the running state. After that edge, `halt_o`, `op_status_o`, `wake_o`, `evt_drive_o`, `cmd_ready_o` and `cmd_accept_o` are all 0, so the line is released.
- R2: A `jtag_dbg_req_i` sampled high while running does not halt the core at once. The block first waits for an `insn_done_i` pulse, then for a later `insn_latched_i` pulse. `halt_o` rises on the edge that samples `insn_latched_i`.
- R3: A falling edge on `evt_line_i` while running counts as a request. It takes effect `SYNC_STAGES` edges later than a JTAG request sampled at the same edge. The block's own acknowledge drive never counts as a new request.
- R4: `op_status_o` is 2'b11 in every cycle that `halt_o` is 1, and 2'b00 in every other cycle.
- R5: `evt_drive_o` (1 = pull the line low) is high for exactly `ACK_CYCLES` cycles. It starts in the same cycle that `halt_o` rises.
- R6: A request that arrives while `stop_state_i` or `wait_state_i` is high skips the wait for retirement. From the next cycle, `wake_o` is 1 until the edge that samples `insn_latched_i`. On that same edge the core halts and `wake_o` drops.
- R7: Requests from either source have no effect while the core is halted. `halt_o` stays 1, `op_status_o` stays 2'b11 and no new acknowledge is driven.
- R8: `cmd_ready_o` rises only after the acknowledge ends and the synchronized line, having been seen low, is seen high again. It stays 1 until a go command is accepted.
- R9: `cmd_valid_i` sampled high while `cmd_ready_o` is 1 gives a one-cycle `cmd_accept_o` pulse after the next edge. A command offered while `cmd_ready_o` is 0 gives no pulse and cannot resume the core.
- R10: An accepted command with `cmd_go_i` = 1 returns the block to running after one edge. After that edge, `halt_o` is 0, `op_status_o` is 2'b00 and `cmd_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jtag_dbg_req_i | input | 1 | Debug request from the JTAG instruction decode |
| evt_line_i | input | 1 | Level read from the open-drain debug-event line (active low) |
| evt_drive_o | output | 1 | Pull-down enable for the debug-event line (acknowledge) |
| insn_done_i | input | 1 | Pulse: the current instruction has retired |
| insn_latched_i | input | 1 | Pulse: a fetched instruction was loaded into the instruction latch |
| stop_state_i | input | 1 | Core is in the stop low-power state |
| wait_state_i | input | 1 | Core is in the wait low-power state |
| cmd_valid_i | input | 1 | Host command offered this cycle |
| cmd_go_i | input | 1 | Offered command is a go (leave debug) command |
| halt_o | output | 1 | Halt request to the core |
| op_status_o | output | 2 | Core operating-status field (11 = debug) |
| wake_o | output | 1 | Wake request out of stop or wait |
| cmd_ready_o | output | 1 | Host commands are now accepted |
| cmd_accept_o | output | 1 | Pulse: a command was accepted |

## Verification
Each output is registered, so a result from an input sampled at an edge is due at that edge. There are two exceptions. A line request passes through the synchronizer first, so its effect comes `SYNC_STAGES` edges later. `cmd_ready_o` appears only after the released line has come back through the same synchronizer, one edge after the synchronized level is seen high.

The bench keeps a behavioural model of these delays, with a short history of line levels. It steps the model at every rising edge with the same inputs as the design. It compares all six outputs at each falling edge, where every register has settled and no new input has been applied yet. Directed checks at the scenario boundaries confirm reset, line-request entry, requests ignored while halted, and the go exit.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_WAIT_RETIRE,
    ST_WAIT_LATCH,
    ST_DEBUG_ACK,
    ST_DEBUG
  } dbg_state_e;
endpackage

// File: rtl/dbg_line_sync.sv
// Synchronizer for the open-drain event line plus falling-edge detect.
module dbg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/dbg_entry_fsm.sv
// Entry sequencing: retire, latch, acknowledge, debug.
module dbg_entry_fsm
  import dbg_entry_pkg::*;
#(
  parameter int ACK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic       lowpow_i,
  input  logic       insn_done_i,
  input  logic       insn_latched_i,
  input  logic       go_i,
  output dbg_state_e state_o,
  output logic       halt_o,
  output logic [1:0] status_o,
  output logic       wake_o,
  output logic       drive_o
);
  localparam int CNT_W = $clog2(ACK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_CYCLES - 1);

  dbg_state_e       st_q, st_n;
  logic             lp_q, lp_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n  = st_q;
    lp_n  = lp_q;
    cnt_n = cnt_q;
    unique case (st_q)
      ST_RUN: if (req_i) begin
        lp_n = lowpow_i;
        st_n = lowpow_i ? ST_WAIT_LATCH : ST_WAIT_RETIRE;
      end
      ST_WAIT_RETIRE: if (insn_done_i) st_n = ST_WAIT_LATCH;
      ST_WAIT_LATCH: if (insn_latched_i) begin
        st_n  = ST_DEBUG_ACK;
        cnt_n = '0;
      end
      ST_DEBUG_ACK: begin
        if (cnt_q == CNT_LAST) st_n = ST_DEBUG;
        else cnt_n = cnt_q + 1'b1;
      end
      ST_DEBUG: if (go_i) begin
        st_n = ST_RUN;
        lp_n = 1'b0;
      end
      default: st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RUN;
      lp_q     <= 1'b0;
      cnt_q    <= '0;
      halt_o   <= 1'b0;
      status_o <= 2'b00;
      wake_o   <= 1'b0;
      drive_o  <= 1'b0;
    end else begin
      st_q     <= st_n;
      lp_q     <= lp_n;
      cnt_q    <= cnt_n;
      halt_o   <= (st_n == ST_DEBUG_ACK) || (st_n == ST_DEBUG);
      status_o <= ((st_n == ST_DEBUG_ACK) || (st_n == ST_DEBUG)) ? 2'b11 : 2'b00;
      wake_o   <= (st_n == ST_WAIT_LATCH) && lp_n;
      drive_o  <= (st_n == ST_DEBUG_ACK);
    end
  end

  assign state_o = st_q;

  p_halt_after_latch_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_o) |-> $past(insn_latched_i));
  p_status_tracks_halt_r4: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> (status_o == 2'b11));
  p_ack_only_halted_r5: assert property (@(posedge clk) disable iff (rst)
    drive_o |-> halt_o);
  p_wake_before_halt_r6: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> !halt_o);
  p_no_reentry_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DEBUG && !go_i) |=> (halt_o && !drive_o));
endmodule

// File: rtl/dbg_cmd_gate.sv
// Holds off host commands until the line is released after the acknowledge.
module dbg_cmd_gate (
  input  logic clk,
  input  logic rst,
  input  logic halted_i,
  input  logic in_debug_i,
  input  logic level_i,
  input  logic cmd_valid_i,
  input  logic cmd_go_i,
  output logic ready_o,
  output logic accept_o,
  output logic go_acc_o
);
  logic seen_low_q;
  logic ready_q;

  assign go_acc_o = cmd_valid_i & cmd_go_i & ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_low_q <= 1'b0;
      ready_q    <= 1'b0;
      accept_o   <= 1'b0;
    end else begin
      seen_low_q <= halted_i ? (seen_low_q | ~level_i) : 1'b0;
      ready_q    <= in_debug_i & ~go_acc_o & (ready_q | (seen_low_q & level_i));
      accept_o   <= cmd_valid_i & ready_q;
    end
  end

  assign ready_o = ready_q;

  p_ready_in_debug_r8: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> in_debug_i);
  p_accept_needs_ready_r9: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> $past(ready_q));
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int ACK_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       jtag_dbg_req_i,
  input  logic       evt_line_i,
  output logic       evt_drive_o,
  input  logic       insn_done_i,
  input  logic       insn_latched_i,
  input  logic       stop_state_i,
  input  logic       wait_state_i,
  input  logic       cmd_valid_i,
  input  logic       cmd_go_i,
  output logic       halt_o,
  output logic [1:0] op_status_o,
  output logic       wake_o,
  output logic       cmd_ready_o,
  output logic       cmd_accept_o
);
  dbg_state_e state;
  logic       line_lvl, line_fall, go_acc;

  dbg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_i(evt_line_i),
    .level_o(line_lvl), .fall_o(line_fall)
  );

  dbg_entry_fsm #(.ACK_CYCLES(ACK_CYCLES)) u_fsm (
    .clk(clk), .rst(rst),
    .req_i(jtag_dbg_req_i | line_fall),
    .lowpow_i(stop_state_i | wait_state_i),
    .insn_done_i(insn_done_i), .insn_latched_i(insn_latched_i),
    .go_i(go_acc), .state_o(state), .halt_o(halt_o),
    .status_o(op_status_o), .wake_o(wake_o), .drive_o(evt_drive_o)
  );

  dbg_cmd_gate u_gate (
    .clk(clk), .rst(rst),
    .halted_i((state == ST_DEBUG_ACK) || (state == ST_DEBUG)),
    .in_debug_i(state == ST_DEBUG),
    .level_i(line_lvl), .cmd_valid_i(cmd_valid_i), .cmd_go_i(cmd_go_i),
    .ready_o(cmd_ready_o), .accept_o(cmd_accept_o), .go_acc_o(go_acc)
  );

  p_go_resumes_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEBUG && go_acc) |=> (!halt_o && op_status_o == 2'b00 && !cmd_ready_o));
  p_reset_released_r1: assert property (@(posedge clk)
    $past(rst) |-> (!evt_drive_o && !halt_o));
endmodule

// File: tb/dbg_entry_ctrl_bench.sv
module dbg_entry_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ACK = 4;
  localparam int SYN = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic jreq = 0, done = 0, latched = 0, stop_s = 0, wait_s = 0;
  logic cvalid = 0, cgo = 0, host_low = 0;
  logic drive, halt, wake, ready, accept;
  logic [1:0] status;
  logic line;

  int checks = 0, errors = 0;
  bit started = 0, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign line = !(drive || host_low);

  dbg_entry_ctrl #(.ACK_CYCLES(ACK), .SYNC_STAGES(SYN)) u_dbg_entry_ctrl (
    .clk(clk), .rst(rst), .jtag_dbg_req_i(jreq), .evt_line_i(line),
    .evt_drive_o(drive), .insn_done_i(done), .insn_latched_i(latched),
    .stop_state_i(stop_s), .wait_state_i(wait_s), .cmd_valid_i(cvalid),
    .cmd_go_i(cgo), .halt_o(halt), .op_status_o(status), .wake_o(wake),
    .cmd_ready_o(ready), .cmd_accept_o(accept)
  );

  // Behavioural reference: phase codes 0 run, 1 retire, 2 latch, 3 ack, 4 debug
  int  m_ph = 0, m_cnt = 0;
  bit  m_lp = 0, m_halt = 0, m_drive = 0, m_wake = 0, m_ready = 0, m_acc = 0, m_seen = 0;
  bit  hist[$];

  always @(posedge clk) begin
    bit fall, lvl, req, go_acc, nready;
    int np;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_lp = 0; m_halt = 0; m_drive = 0; m_wake = 0;
      m_ready = 0; m_acc = 0; m_seen = 0;
      hist = {};
      for (int i = 0; i < SYN + 1; i++) hist.push_back(1'b1);
    end else begin
      lvl = hist[SYN-1];
      fall = hist[SYN] && !lvl;
      req = jreq || fall;
      go_acc = cvalid && cgo && m_ready;
      np = m_ph;
      if (m_ph == 0 && req) begin
        m_lp = stop_s || wait_s;
        np = m_lp ? 2 : 1;
      end else if (m_ph == 1 && done) np = 2;
      else if (m_ph == 2 && latched) begin np = 3; m_cnt = 0; end
      else if (m_ph == 3) begin
        if (m_cnt == ACK - 1) np = 4; else m_cnt++;
      end else if (m_ph == 4 && go_acc) begin np = 0; m_lp = 0; end
      nready = (m_ph == 4) && !go_acc && (m_ready || (m_seen && lvl));
      m_seen = (m_ph == 3 || m_ph == 4) ? (m_seen || !lvl) : 0;
      m_acc = cvalid && m_ready;
      m_ready = nready;
      hist.push_front(!(m_drive || host_low));
      void'(hist.pop_back());
      m_ph = np;
      m_halt = (np == 3 || np == 4);
      m_drive = (np == 3);
      m_wake = (np == 2) && m_lp;
    end
    started = 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(halt == m_halt, "R2 halt_o", halt, m_halt);
      chk(status == {m_halt, m_halt}, "R4 op_status_o", status, {m_halt, m_halt});
      chk(drive == m_drive, "R5 evt_drive_o", drive, m_drive);
      chk(wake == m_wake, "R6 wake_o", wake, m_wake);
      chk(ready == m_ready, "R8 cmd_ready_o", ready, m_ready);
      chk(accept == m_acc, "R9 cmd_accept_o", accept, m_acc);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; cyc(1); s = 0;
  endtask

  task automatic go_cmd();
    cvalid = 1; cgo = 1; cyc(1); cvalid = 0; cgo = 0;
  endtask

  task automatic release_and_ready();
    cyc(ACK + 1);
    host_low = 1; cyc(2); host_low = 0;
    cyc(SYN + 3);
  endtask

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    chk(halt == 0 && drive == 0 && status == 0, "R1 reset state", {halt, drive}, 0);

    // R2/R5/R8/R9/R10: JTAG request while running
    pulse(jreq); cyc(3);
    chk(halt == 0, "R2 no halt before retire", halt, 0);
    pulse(done); cyc(2);
    chk(halt == 0, "R2 no halt before latch", halt, 0);
    pulse(latched);
    chk(halt == 1 && drive == 1, "R5 ack with halt", {halt, drive}, 3);
    cvalid = 1; cgo = 1; cyc(1); cvalid = 0; cgo = 0;   // R9 early go ignored
    chk(halt == 1 && accept == 0, "R9 early command ignored", {halt, accept}, 2);
    release_and_ready();
    chk(ready == 1, "R8 ready after release", ready, 1);
    pulse(cvalid); cyc(1);
    go_cmd();
    chk(halt == 0 && status == 0 && ready == 0, "R10 go resumes", {halt, status, ready}, 0);
    cyc(3);

    // R3/R7: line request, then requests while halted
    host_low = 1; cyc(2); host_low = 0;
    cyc(2); pulse(done); cyc(1); pulse(latched);
    chk(halt == 1, "R3 line request halts", halt, 1);
    release_and_ready();
    pulse(jreq); host_low = 1; cyc(1); host_low = 0; cyc(SYN + 3);
    chk(halt == 1 && status == 3 && drive == 0, "R7 request ignored in debug", {halt, drive}, 2);
    go_cmd(); cyc(4);

    // R6: stop state with JTAG request
    stop_s = 1; pulse(jreq); cyc(2);
    chk(wake == 1 && halt == 0, "R6 wake from stop", {wake, halt}, 2);
    pulse(latched); stop_s = 0;
    chk(halt == 1 && wake == 0, "R6 halt after latch", {wake, halt}, 1);
    release_and_ready(); go_cmd(); cyc(3);

    // R6/R3: wait state with line request
    wait_s = 1; host_low = 1; cyc(1); host_low = 0; cyc(SYN + 2);
    chk(wake == 1, "R6 wake from wait", wake, 1);
    pulse(latched); wait_s = 0;
    release_and_ready(); go_cmd(); cyc(3);

    // R1: reset during acknowledge
    pulse(jreq); pulse(done); pulse(latched); cyc(1);
    rst = 1; cyc(1); rst = 0; cyc(1);
    chk(drive == 0 && halt == 0, "R1 reset releases line", {drive, halt}, 0);
    cyc(4);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule